// File: doc/BRIEF.md
# Byte-Striped Parity Array Engine

This block makes four lockstep byte channels look like one wide storage device. On the write side it takes a stream of bytes and deals them out in rotation across three data channels. For every group of three it also produces a fourth byte, the bit-wise XOR of the group, for a dedicated parity channel. All four channel bytes leave together in a single beat. Parity therefore costs one channel in four.

On the read side it accepts one four-byte beat from the channels. If a channel is declared failed, it replaces that channel's byte with the XOR of the other three. It then hands the data bytes out one per transfer, in their original stream order. When no channel is marked failed, it checks that the four bytes XOR to zero and flags any beat that does not.

The failed-channel selection is taken with each beat. Rebuilding a lost channel therefore goes on while ordinary traffic keeps flowing. Every stream edge uses valid/ready handshaking. A record whose length is not a multiple of three is closed with zero padding, and that beat is flagged.

Top module: `stripe_parity_array`

## Requirements
- R1: While reset is active, and after it is released with no traffic, `wr_in_ready` and `ch_rd_ready` are 1, and `ch_wr_valid` and `rd_out_valid` are 0.
- R2: Within a write group, the k-th accepted byte (k = 0 first) appears on data channel k, which is bits [8k+7:8k] of `ch_wr_data`.
- R3: The parity channel, bits [31:24] of `ch_wr_data`, equals the XOR of the three data channel bytes of the same beat, so all four bytes XOR to zero.
- R4: While `ch_wr_valid` is 1 and `ch_wr_ready` is 0, `ch_wr_data` and `ch_wr_partial` hold their values, and `wr_in_ready` is 0.
- R5: A byte with `wr_in_last` set at group position 0 or 1 closes the group. The unfilled data slots are 0 and `ch_wr_partial` is 1. A group closed at position 2 has `ch_wr_partial` 0.
- R6: With no channel failed, a read beat yields the bytes of channels 0, 1 and 2 in that order on `rd_out_data`. The parity byte is never emitted.
- R7: With `fail_valid` 1 and `fail_idx` in 0..2, the byte emitted for that channel is the XOR of the other three channel bytes. The byte actually presented on the failed channel has no effect.
- R8: With `fail_valid` 1 and `fail_idx` 3 (the parity channel), the data bytes are emitted unchanged and `rd_out_perr` is 0.
- R9: With `fail_valid` 0, a beat whose four bytes do not XOR to zero gives `rd_out_perr` 1 on all three of its output bytes, and a beat that does XOR to zero gives 0. With `fail_valid` 1, `rd_out_perr` is 0.
- R10: While `rd_out_valid` is 1 and `rd_out_ready` is 0, `rd_out_data` and `rd_out_perr` hold their values, and `ch_rd_ready` is 0.
- R11: `fail_valid` and `fail_idx` are sampled in the cycle a read beat is accepted. Back-to-back beats may each use a different failed channel with no gap in the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fail_valid | input | 1 | A channel is marked failed |
| fail_idx | input | 2 | Index of the failed channel (3 = parity) |
| wr_in_valid | input | 1 | Write byte valid |
| wr_in_ready | output | 1 | Write byte accepted |
| wr_in_data | input | 8 | Write byte |
| wr_in_last | input | 1 | Last byte of the record |
| ch_wr_valid | output | 1 | Channel write beat valid |
| ch_wr_ready | input | 1 | Channels take the beat |
| ch_wr_data | output | 32 | Four channel bytes, channel c at [8c+7:8c] |
| ch_wr_partial | output | 1 | Beat was zero-padded |
| ch_rd_valid | input | 1 | Channel read beat valid |
| ch_rd_ready | output | 1 | Read beat accepted |
| ch_rd_data | input | 32 | Four channel bytes, channel c at [8c+7:8c] |
| rd_out_valid | output | 1 | Output byte valid |
| rd_out_ready | input | 1 | Output byte taken |
| rd_out_data | output | 8 | Output byte |
| rd_out_perr | output | 1 | Byte comes from a beat with a parity mismatch |

## Verification
The bench uses the default build: three data channels of eight bits. With that build, every slot position can close a record: one-byte and two-byte partial groups as well as full ones. Every channel index, including the parity channel, can be named as failed. The write and read streams run at the same time, each under its own periodic back-pressure. Directed stalls then hold each side still so that the hold behaviour can be observed.

// File: rtl/spa_pkg.sv
`timescale 1ns/1ps
package spa_pkg;
  // Width of an index able to address n items, never below one bit.
  function automatic int unsigned spa_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/spa_wr_striper.sv
`timescale 1ns/1ps
module spa_wr_striper #(
  parameter int unsigned DATA_CH = 3,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [BYTE_W-1:0]                 in_data,
  input  logic                              in_last,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [(DATA_CH+1)*BYTE_W-1:0]     out_data,
  output logic                              out_partial
);
  localparam int unsigned NCH = DATA_CH + 1;
  localparam int unsigned PW  = spa_pkg::spa_idx_w(DATA_CH);
  localparam logic [PW-1:0] LAST_POS = PW'(DATA_CH - 1);

  logic [DATA_CH-1:0][BYTE_W-1:0] slot_q, slot_d;
  logic [PW-1:0]                  pos_q, pos_d;
  logic                           hold_q, hold_d;
  logic                           part_q, part_d;
  logic                           in_fire, out_fire, close_grp;
  logic [BYTE_W-1:0]              par_byte;

  assign in_ready  = !hold_q || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = hold_q && out_ready;
  assign close_grp = in_last || (pos_q == LAST_POS);

  always_comb begin
    slot_d = slot_q;
    pos_d  = pos_q;
    hold_d = hold_q;
    part_d = part_q;
    if (out_fire) begin
      hold_d = 1'b0;
    end
    if (in_fire) begin
      if (pos_q == '0) begin
        for (int k = 0; k < DATA_CH; k++) begin
          slot_d[k] = '0;
        end
      end
      slot_d[pos_q] = in_data;
      if (close_grp) begin
        hold_d = 1'b1;
        part_d = (pos_q != LAST_POS);
        pos_d  = '0;
      end else begin
        pos_d = pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pos_q  <= '0;
      hold_q <= 1'b0;
      part_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      pos_q  <= pos_d;
      hold_q <= hold_d;
      part_q <= part_d;
    end
  end

  always_comb begin
    par_byte = '0;
    for (int k = 0; k < DATA_CH; k++) begin
      par_byte = par_byte ^ slot_q[k];
    end
  end

  for (genvar g = 0; g < DATA_CH; g++) begin : g_lane
    assign out_data[g*BYTE_W +: BYTE_W] = slot_q[g];
  end
  assign out_data[DATA_CH*BYTE_W +: BYTE_W] = par_byte;

  assign out_valid   = hold_q;
  assign out_partial = part_q;

  logic unused_nch;
  assign unused_nch = (NCH == 0);
endmodule

// File: rtl/spa_rd_rebuild.sv
`timescale 1ns/1ps
module spa_rd_rebuild #(
  parameter int unsigned DATA_CH = 3,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic [(DATA_CH+1)*BYTE_W-1:0]              beat,
  input  logic                                       fail_valid,
  input  logic [spa_pkg::spa_idx_w(DATA_CH+1)-1:0]   fail_idx,
  output logic [DATA_CH-1:0][BYTE_W-1:0]             fixed,
  output logic                                       perr
);
  localparam int unsigned NCH = DATA_CH + 1;
  localparam int unsigned FW  = spa_pkg::spa_idx_w(NCH);

  logic [BYTE_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int c = 0; c < NCH; c++) begin
      sum = sum ^ beat[c*BYTE_W +: BYTE_W];
    end
  end

  // The XOR of all four with the lost byte removed is the XOR of the others.
  for (genvar g = 0; g < DATA_CH; g++) begin : g_fix
    logic [BYTE_W-1:0] own;
    logic              lost;
    assign own      = beat[g*BYTE_W +: BYTE_W];
    assign lost     = fail_valid && (fail_idx == FW'(g));
    assign fixed[g] = lost ? (sum ^ own) : own;
  end

  assign perr = !fail_valid && (sum != '0);
endmodule

// File: rtl/spa_rd_serial.sv
`timescale 1ns/1ps
module spa_rd_serial #(
  parameter int unsigned DATA_CH = 3,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [DATA_CH-1:0][BYTE_W-1:0] in_bytes,
  input  logic                           in_perr,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [BYTE_W-1:0]              out_data,
  output logic                           out_perr
);
  localparam int unsigned SW = spa_pkg::spa_idx_w(DATA_CH);
  localparam logic [SW-1:0] LAST_SEL = SW'(DATA_CH - 1);

  logic [DATA_CH-1:0][BYTE_W-1:0] byte_q, byte_d;
  logic [SW-1:0]                  sel_q, sel_d;
  logic                           full_q, full_d;
  logic                           perr_q, perr_d;
  logic                           in_fire, out_fire, at_last;

  assign at_last  = (sel_q == LAST_SEL);
  assign out_fire = full_q && out_ready;
  assign in_ready = !full_q || (out_ready && at_last);
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    byte_d = byte_q;
    sel_d  = sel_q;
    full_d = full_q;
    perr_d = perr_q;
    if (out_fire) begin
      if (at_last) begin
        full_d = 1'b0;
        sel_d  = '0;
      end else begin
        sel_d = sel_q + SW'(1);
      end
    end
    if (in_fire) begin
      byte_d = in_bytes;
      perr_d = in_perr;
      full_d = 1'b1;
      sel_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      sel_q  <= '0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      byte_q <= byte_d;
      sel_q  <= sel_d;
      full_q <= full_d;
      perr_q <= perr_d;
    end
  end

  assign out_valid = full_q;
  assign out_data  = byte_q[sel_q];
  assign out_perr  = perr_q;
endmodule

// File: rtl/stripe_parity_array.sv
`timescale 1ns/1ps
module stripe_parity_array #(
  parameter int unsigned DATA_CH = 3,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       fail_valid,
  input  logic [spa_pkg::spa_idx_w(DATA_CH+1)-1:0]   fail_idx,
  input  logic                                       wr_in_valid,
  output logic                                       wr_in_ready,
  input  logic [BYTE_W-1:0]                          wr_in_data,
  input  logic                                       wr_in_last,
  output logic                                       ch_wr_valid,
  input  logic                                       ch_wr_ready,
  output logic [(DATA_CH+1)*BYTE_W-1:0]              ch_wr_data,
  output logic                                       ch_wr_partial,
  input  logic                                       ch_rd_valid,
  output logic                                       ch_rd_ready,
  input  logic [(DATA_CH+1)*BYTE_W-1:0]              ch_rd_data,
  output logic                                       rd_out_valid,
  input  logic                                       rd_out_ready,
  output logic [BYTE_W-1:0]                          rd_out_data,
  output logic                                       rd_out_perr
);
  // Reset asserts at once and is released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  spa_wr_striper #(.DATA_CH(DATA_CH), .BYTE_W(BYTE_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .in_valid    (wr_in_valid),
    .in_ready    (wr_in_ready),
    .in_data     (wr_in_data),
    .in_last     (wr_in_last),
    .out_valid   (ch_wr_valid),
    .out_ready   (ch_wr_ready),
    .out_data    (ch_wr_data),
    .out_partial (ch_wr_partial)
  );

  logic [DATA_CH-1:0][BYTE_W-1:0] fixed_bytes;
  logic                           fixed_perr;

  spa_rd_rebuild #(.DATA_CH(DATA_CH), .BYTE_W(BYTE_W)) u_fix (
    .beat       (ch_rd_data),
    .fail_valid (fail_valid),
    .fail_idx   (fail_idx),
    .fixed      (fixed_bytes),
    .perr       (fixed_perr)
  );

  spa_rd_serial #(.DATA_CH(DATA_CH), .BYTE_W(BYTE_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (ch_rd_valid),
    .in_ready  (ch_rd_ready),
    .in_bytes  (fixed_bytes),
    .in_perr   (fixed_perr),
    .out_valid (rd_out_valid),
    .out_ready (rd_out_ready),
    .out_data  (rd_out_data),
    .out_perr  (rd_out_perr)
  );
endmodule

// File: rtl/spa_checker.sv
`timescale 1ns/1ps
module spa_checker #(
  parameter int unsigned DATA_CH = 3,
  parameter int unsigned BYTE_W  = 8
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     fail_valid,
  input logic [spa_pkg::spa_idx_w(DATA_CH+1)-1:0] fail_idx,
  input logic                                     wr_in_ready,
  input logic                                     ch_wr_valid,
  input logic                                     ch_wr_ready,
  input logic [(DATA_CH+1)*BYTE_W-1:0]            ch_wr_data,
  input logic                                     ch_wr_partial,
  input logic                                     ch_rd_valid,
  input logic                                     ch_rd_ready,
  input logic [(DATA_CH+1)*BYTE_W-1:0]            ch_rd_data,
  input logic                                     rd_out_valid,
  input logic                                     rd_out_ready,
  input logic [BYTE_W-1:0]                        rd_out_data,
  input logic                                     rd_out_perr
);
  localparam int unsigned NCH = DATA_CH + 1;

  logic [BYTE_W-1:0] wr_sum, rd_sum, rd_rest0;
  logic              rd_fire;

  always_comb begin
    wr_sum   = '0;
    rd_sum   = '0;
    rd_rest0 = '0;
    for (int c = 0; c < NCH; c++) begin
      wr_sum = wr_sum ^ ch_wr_data[c*BYTE_W +: BYTE_W];
      rd_sum = rd_sum ^ ch_rd_data[c*BYTE_W +: BYTE_W];
      if (c != 0) rd_rest0 = rd_rest0 ^ ch_rd_data[c*BYTE_W +: BYTE_W];
    end
  end
  assign rd_fire = ch_rd_valid && ch_rd_ready;

  AST_WR_ZERO_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_valid |-> (wr_sum == '0)); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_valid && !ch_wr_ready |=> ch_wr_valid && $stable(ch_wr_data) && $stable(ch_wr_partial)); // R4
  AST_WR_BACKPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_valid && !ch_wr_ready |-> !wr_in_ready); // R4
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_valid && ch_wr_partial |-> (ch_wr_data[(DATA_CH-1)*BYTE_W +: BYTE_W] == '0)); // R5
  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && !fail_valid |=> rd_out_valid && (rd_out_data == $past(ch_rd_data[BYTE_W-1:0]))); // R6
  AST_REBUILD0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && fail_valid && (fail_idx == '0) |=> rd_out_valid && (rd_out_data == $past(rd_rest0))); // R7
  AST_PERR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && fail_valid |=> !rd_out_perr); // R9
  AST_PERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && (rd_sum == '0) |=> !rd_out_perr); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid && !rd_out_ready |=> rd_out_valid && $stable(rd_out_data) && $stable(rd_out_perr)); // R10
  AST_OUT_BACKPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid && !rd_out_ready |-> !ch_rd_ready); // R10
endmodule

bind stripe_parity_array spa_checker #(.DATA_CH(DATA_CH), .BYTE_W(BYTE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fail_valid    (fail_valid),
  .fail_idx      (fail_idx),
  .wr_in_ready   (wr_in_ready),
  .ch_wr_valid   (ch_wr_valid),
  .ch_wr_ready   (ch_wr_ready),
  .ch_wr_data    (ch_wr_data),
  .ch_wr_partial (ch_wr_partial),
  .ch_rd_valid   (ch_rd_valid),
  .ch_rd_ready   (ch_rd_ready),
  .ch_rd_data    (ch_rd_data),
  .rd_out_valid  (rd_out_valid),
  .rd_out_ready  (rd_out_ready),
  .rd_out_data   (rd_out_data),
  .rd_out_perr   (rd_out_perr)
);

// File: tb/stripe_parity_array_tb.sv
`timescale 1ns/1ps
module stripe_parity_array_tb;
  localparam int DC  = 3;
  localparam int BW  = 8;
  localparam int NCH = DC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              fail_valid = 1'b0;
  logic [1:0]        fail_idx = '0;
  logic              wr_in_valid = 1'b0;
  logic              wr_in_ready;
  logic [BW-1:0]     wr_in_data = '0;
  logic              wr_in_last = 1'b0;
  logic              ch_wr_valid;
  logic              ch_wr_ready = 1'b1;
  logic [NCH*BW-1:0] ch_wr_data;
  logic              ch_wr_partial;
  logic              ch_rd_valid = 1'b0;
  logic              ch_rd_ready;
  logic [NCH*BW-1:0] ch_rd_data = '0;
  logic              rd_out_valid;
  logic              rd_out_ready = 1'b1;
  logic [BW-1:0]     rd_out_data;
  logic              rd_out_perr;

  stripe_parity_array #(.DATA_CH(DC), .BYTE_W(BW)) u_dut (.*);

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [NCH*BW-1:0] data; logic part; } wexp_t;
  typedef struct { logic [BW-1:0] b; logic perr; string req; } rexp_t;
  wexp_t wq[$];
  rexp_t rq[$];
  wexp_t we;
  rexp_t re;
  logic [BW-1:0] grp [DC];
  int gpos = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Periodic back-pressure, driven just after each rising edge.
  bit wr_hold = 1'b0, rd_hold = 1'b0;
  int tick = 0;
  always @(posedge clk) begin
    #1;
    tick++;
    if (!wr_hold) ch_wr_ready = (tick % 5) != 2;
    if (!rd_hold) rd_out_ready = (tick % 3) != 1;
  end

  // Write-side monitor.
  always @(negedge clk) begin
    if (rst_n && ch_wr_valid && ch_wr_ready) begin
      if (wq.size() == 0) begin
        check(1'b0, "R2", "unexpected write beat", ch_wr_data, 0);
      end else begin
        we = wq.pop_front();
        for (int k = 0; k < DC; k++)
          check(ch_wr_data[k*BW +: BW] == we.data[k*BW +: BW], "R2", "data lane",
                ch_wr_data[k*BW +: BW], we.data[k*BW +: BW]);
        check(ch_wr_data[DC*BW +: BW] == we.data[DC*BW +: BW], "R3", "parity lane",
              ch_wr_data[DC*BW +: BW], we.data[DC*BW +: BW]);
        check(ch_wr_partial == we.part, "R5", "partial flag", ch_wr_partial, we.part);
      end
    end
  end

  // Read-side monitor.
  always @(negedge clk) begin
    if (rst_n && rd_out_valid && rd_out_ready) begin
      if (rq.size() == 0) begin
        check(1'b0, "R6", "unexpected output byte", rd_out_data, 0);
      end else begin
        re = rq.pop_front();
        check(rd_out_data == re.b, re.req, "output byte", rd_out_data, re.b);
        check(rd_out_perr == re.perr, re.req, "parity error flag", rd_out_perr, re.perr);
      end
    end
  end

  task automatic wr_byte(input logic [BW-1:0] b, input bit last);
    wexp_t e;
    logic [BW-1:0] p;
    if (gpos == 0) for (int k = 0; k < DC; k++) grp[k] = '0;
    grp[gpos] = b;
    if (last || gpos == DC - 1) begin
      p = '0;
      for (int k = 0; k < DC; k++) begin
        e.data[k*BW +: BW] = grp[k];
        p = p ^ grp[k];
      end
      e.data[DC*BW +: BW] = p;
      e.part = (gpos != DC - 1);
      wq.push_back(e);
      gpos = 0;
    end else begin
      gpos++;
    end
    wr_in_valid = 1'b1;
    wr_in_data  = b;
    wr_in_last  = last;
    do @(negedge clk); while (!wr_in_ready);
    @(posedge clk); #1;
    wr_in_valid = 1'b0;
    wr_in_last  = 1'b0;
  endtask

  task automatic rd_beat(input logic [BW-1:0] c0, input logic [BW-1:0] c1,
                         input logic [BW-1:0] c2, input logic [BW-1:0] c3,
                         input bit fv, input logic [1:0] fi, input string req);
    logic [BW-1:0] c [NCH];
    logic [BW-1:0] sum, x;
    rexp_t e;
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
    sum = c0 ^ c1 ^ c2 ^ c3;
    for (int k = 0; k < DC; k++) begin
      if (fv && fi == 2'(k)) begin
        x = '0;
        for (int j = 0; j < NCH; j++) if (j != k) x = x ^ c[j];
        e.b = x;
      end else begin
        e.b = c[k];
      end
      e.perr = !fv && (sum != '0);
      e.req  = req;
      rq.push_back(e);
    end
    ch_rd_valid = 1'b1;
    ch_rd_data  = {c3, c2, c1, c0};
    fail_valid  = fv;
    fail_idx    = fi;
    do @(negedge clk); while (!ch_rd_ready);
    @(posedge clk); #1;
    ch_rd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  logic [NCH*BW-1:0] snap_w;
  logic [BW-1:0]     snap_r;

  initial begin
    // R1: reset state, during and after reset.
    repeat (3) @(negedge clk);
    check(wr_in_ready == 1'b1, "R1", "wr_in_ready in reset", wr_in_ready, 1);
    check(ch_wr_valid == 1'b0, "R1", "ch_wr_valid in reset", ch_wr_valid, 0);
    check(ch_rd_ready == 1'b1, "R1", "ch_rd_ready in reset", ch_rd_ready, 1);
    check(rd_out_valid == 1'b0, "R1", "rd_out_valid in reset", rd_out_valid, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wr_in_ready == 1'b1 && ch_rd_ready == 1'b1, "R1", "ready after reset",
          {wr_in_ready, ch_rd_ready}, 2'b11);
    check(ch_wr_valid == 1'b0 && rd_out_valid == 1'b0, "R1", "valid after reset",
          {ch_wr_valid, rd_out_valid}, 0);
    @(posedge clk); #1;

    fork
      begin
        // R2/R3: full groups with assorted patterns.
        wr_byte(8'h11, 0); wr_byte(8'h22, 0); wr_byte(8'h44, 0);
        wr_byte(8'hA5, 0); wr_byte(8'h5A, 0); wr_byte(8'hFF, 0);
        wr_byte(8'h00, 0); wr_byte(8'h00, 0); wr_byte(8'h00, 0);
        // R5: record of one byte, of two bytes, and closing at the last slot.
        wr_byte(8'h3C, 1);
        wr_byte(8'h81, 0); wr_byte(8'h7E, 1);
        wr_byte(8'h01, 0); wr_byte(8'h02, 0); wr_byte(8'h03, 1);
        wr_byte(8'hFF, 0); wr_byte(8'hFF, 0); wr_byte(8'hFF, 0);
      end
      begin
        // R6: clean beats, parity lane consistent.
        rd_beat(8'h10, 8'h20, 8'h40, 8'h70, 0, 0, "R6");
        rd_beat(8'hDE, 8'hAD, 8'hBE, 8'hDE ^ 8'hAD ^ 8'hBE, 0, 0, "R6");
        // R9: mismatched beat with no failure.
        rd_beat(8'h01, 8'h02, 8'h04, 8'h00, 0, 0, "R9");
        // R7: each data channel failed, with junk on the failed lane.
        rd_beat(8'hEE, 8'h22, 8'h33, 8'h11 ^ 8'h22 ^ 8'h33, 1, 0, "R7");
        rd_beat(8'h44, 8'hEE, 8'h66, 8'h44 ^ 8'h55 ^ 8'h66, 1, 1, "R7");
        rd_beat(8'h77, 8'h88, 8'hEE, 8'h77 ^ 8'h88 ^ 8'h99, 1, 2, "R7");
        // R8: parity channel failed, its byte is garbage.
        rd_beat(8'hC1, 8'hC2, 8'hC3, 8'h5A, 1, 3, "R8");
        // R11: back-to-back beats, failed channel changes every beat.
        rd_beat(8'h00, 8'hB0, 8'hC0, 8'hA0 ^ 8'hB0 ^ 8'hC0, 1, 0, "R11");
        rd_beat(8'hA1, 8'hB1, 8'hC1, 8'hA1 ^ 8'hB1 ^ 8'hC1, 0, 0, "R11");
        rd_beat(8'hA2, 8'hB2, 8'h00, 8'hA2 ^ 8'hB2 ^ 8'hC2, 1, 2, "R11");
        rd_beat(8'hA3, 8'h00, 8'hC3, 8'hA3 ^ 8'hB3 ^ 8'hC3, 1, 1, "R11");
      end
    join
    fail_valid = 1'b0;

    // R4: hold the channel write side and watch the beat stay put.
    while (wq.size() != 0) @(posedge clk);
    @(posedge clk); #1;
    wr_hold = 1'b1; ch_wr_ready = 1'b0;
    wr_byte(8'h96, 0); wr_byte(8'h69, 0); wr_byte(8'hC3, 0);
    @(negedge clk);
    snap_w = ch_wr_data;
    check(ch_wr_valid == 1'b1, "R4", "beat presented while held", ch_wr_valid, 1);
    check(wr_in_ready == 1'b0, "R4", "wr_in_ready while held", wr_in_ready, 0);
    repeat (3) @(negedge clk);
    check(ch_wr_data == snap_w, "R4", "beat stable while held", ch_wr_data, snap_w);
    check(wr_in_ready == 1'b0, "R4", "wr_in_ready still low", wr_in_ready, 0);
    @(posedge clk); #1; wr_hold = 1'b0;

    // R10: hold the output side and watch the byte stay put.
    while (rq.size() != 0) @(posedge clk);
    @(posedge clk); #1;
    rd_hold = 1'b1; rd_out_ready = 1'b0;
    rd_beat(8'h5C, 8'h6D, 8'h7E, 8'h5C ^ 8'h6D ^ 8'h7E, 0, 0, "R10");
    @(negedge clk);
    snap_r = rd_out_data;
    check(rd_out_valid == 1'b1 && snap_r == 8'h5C, "R10", "first byte held",
          {rd_out_valid, snap_r}, {1'b1, 8'h5C});
    check(ch_rd_ready == 1'b0, "R10", "ch_rd_ready while held", ch_rd_ready, 0);
    repeat (3) @(negedge clk);
    check(rd_out_data == snap_r, "R10", "byte stable while held", rd_out_data, snap_r);
    @(posedge clk); #1; rd_hold = 1'b0;

    repeat (40) @(posedge clk);
    check(wq.size() == 0, "R2", "write beats outstanding", wq.size(), 0);
    check(rq.size() == 0, "R6", "output bytes outstanding", rq.size(), 0);
    finish_run();
  end
endmodule